// File: doc/BRIEF.md
# Integer Arithmetic-and-Branch Unit

This unit evaluates one conditional-branch operation per cycle on two integer operands. The operation is a subtract, an add, an increment, a bitwise AND/OR/XOR, a compare or a bit test. The operand width is chosen per operation as 8, 16, 32 or 64 bits. The unit returns the width-masked arithmetic result and a taken flag. It also raises a fault flag when the operand-type code or the condition index is not supported.

The unit sits in the execute stage of a processor pipeline, next to the branch target adder. The issue logic presents an operation with `in_valid` high. One clock later the unit presents the result, the decision and the fault flag with `out_valid` high. Target arithmetic and register write-back are done by the surrounding pipeline.

The 7-bit opcode has three fields:
- bits [6:4] select the operation family;
- bits [3:1] select a condition within that family;
- bit 0 inverts the decision.

Top module: `abu_top`

## Requirements
- R1: `in_type` codes 0, 1, 2 and 3 select widths of 8, 16, 32 and 64 bits. Both operands are masked to the width before any operation. `out_result` bits at and above the width are zero, and the sign bit is the top bit of the width.
- R2: Each operation accepted with `in_valid` high appears on the outputs exactly one clock later, with `out_valid` high. A synchronous active-low reset clears `out_valid`, `out_result`, `out_taken` and `out_fault` to zero.
- R3: Family 0 (opcode[6:4]=0) yields a−b. Its conditions are selected by opcode[3:1]: 0 result zero, 1 result negative, 2 result positive (sign clear and non-zero), 3 signed overflow, 4 borrow. A borrow is flagged when the masked result is greater than the masked a.
- R4: Family 1 yields a+b with the same conditions 0 to 3 as family 0. Condition 4 is carry, which is flagged when the masked result is less than the masked a.
- R5: Signed overflow on subtract is flagged when a and b differ in sign and the result's sign differs from a's sign. Signed overflow on add is flagged when a and b share a sign and the result's sign differs from a's sign.
- R6: Families 2, 3 and 4 yield a AND b, a OR b and a XOR b respectively. Their only condition is 0, which is true when the masked result is zero.
- R7: Family 5 compares the operands and yields a result of zero. Its conditions are: 0 equal, 1 signed less-than, 2 signed greater-than, 3 unsigned less-than, 4 unsigned greater-than. A signed comparison flips the sign bit of both masked operands and then compares them unsigned.
- R8: Family 6 yields a result of zero. Condition 0 is true when bit b of a is set. Here b is the masked b, and an index at or beyond the width reads as zero. Condition 1 is true when (a AND b) equals b. Condition 2 is true when (a AND b) is non-zero.
- R9: Family 7 yields a+1. Condition 0 is true when a+1 is signed less-than b. Condition 1 is true when a+1 is signed greater-than b.
- R10: Opcode bit 0 inverts the branch decision for every family and condition.
- R11: A type code above 3, or a condition index not listed for the family, sets `out_fault`. In that case `out_taken` is low and `out_result` is zero.
- R12: A cycle with `in_valid` low gives `out_valid` low on the next cycle and leaves `out_result`, `out_taken` and `out_fault` unchanged, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 7 | Family [6:4], condition [3:1], invert [0] |
| in_type | input | 3 | Operand width code |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Outputs carry a new operation |
| out_result | output | 64 | Width-masked result |
| out_taken | output | 1 | Branch decision |
| out_fault | output | 1 | Unsupported type or condition |

## Verification
The hardest situations to reach from the ports are flags computed at a narrow width while the operands carry non-zero bits above that width. Examples are signed overflow and carry at 8 bits, or an equality that holds only after masking. In these cases a design that ignores the mask still looks right on clean operands. The stimulus therefore places deliberate garbage in the upper bits at the boundary values 0x7F, 0x80 and 0xFF. It also uses bit-test indices that equal the width or wrap into range only after masking. These directed cases are followed by a long random mix over every legal family, condition and width, checked against an independent model built on sign extension and widened sums.

// File: rtl/abu_pkg.sv
// Package: shared encodings of the arithmetic-and-branch unit.
// Assumes the opcode layout family[6:4], condition[3:1], invert[0].
package abu_pkg;

    localparam int FAM_W  = 3;
    localparam int COND_W = 3;
    localparam int OP_W   = FAM_W + COND_W + 1;

    typedef enum logic [FAM_W-1:0] {
        FAM_SUB = 3'd0,
        FAM_ADD = 3'd1,
        FAM_AND = 3'd2,
        FAM_OR  = 3'd3,
        FAM_XOR = 3'd4,
        FAM_CMP = 3'd5,
        FAM_TST = 3'd6,
        FAM_INC = 3'd7
    } fam_e;

    // condition indices of the add/subtract families
    localparam logic [COND_W-1:0] CA_ZERO = 3'd0;
    localparam logic [COND_W-1:0] CA_NEG  = 3'd1;
    localparam logic [COND_W-1:0] CA_POS  = 3'd2;
    localparam logic [COND_W-1:0] CA_OVF  = 3'd3;
    localparam logic [COND_W-1:0] CA_CY   = 3'd4;

    // condition indices of the compare family
    localparam logic [COND_W-1:0] CC_EQ   = 3'd0;
    localparam logic [COND_W-1:0] CC_SLT  = 3'd1;
    localparam logic [COND_W-1:0] CC_SGT  = 3'd2;
    localparam logic [COND_W-1:0] CC_ULT  = 3'd3;
    localparam logic [COND_W-1:0] CC_UGT  = 3'd4;

    // condition indices of the bit-test family
    localparam logic [COND_W-1:0] CT_BIT  = 3'd0;
    localparam logic [COND_W-1:0] CT_ALL  = 3'd1;
    localparam logic [COND_W-1:0] CT_ANY  = 3'd2;

    // condition indices of the increment-compare family
    localparam logic [COND_W-1:0] CI_LT   = 3'd0;
    localparam logic [COND_W-1:0] CI_GT   = 3'd1;

endpackage

// File: rtl/abu_width_decode.sv
// Width decoder: turns an operand-type code into a data mask, a sign-bit
// vector and the width in bits. The widths double from DATA_W>>(NUM_WIDTHS-1)
// up to DATA_W. Codes at or above NUM_WIDTHS are flagged as unsupported and
// give an all-zero mask.
module abu_width_decode #(
    parameter int DATA_W     = 64,
    parameter int TYPE_W     = 3,
    parameter int NUM_WIDTHS = 4,
    parameter int IDX_W      = $clog2(DATA_W) + 1
) (
    input  logic [TYPE_W-1:0] type_code,
    output logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] sign_bit,
    output logic [IDX_W-1:0]  width_bits,
    output logic              type_ok
);
    localparam int SEL_W = (NUM_WIDTHS > 1) ? $clog2(NUM_WIDTHS) : 1;

    logic [DATA_W-1:0] mask_tab  [NUM_WIDTHS];
    logic [DATA_W-1:0] sign_tab  [NUM_WIDTHS];
    logic [IDX_W-1:0]  width_tab [NUM_WIDTHS];

    // one table entry per supported width
    for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
        localparam int WK = DATA_W >> (NUM_WIDTHS - 1 - k);
        if (WK == DATA_W) begin : g_full
            assign mask_tab[k] = '1;
        end else begin : g_part
            assign mask_tab[k] = {{(DATA_W-WK){1'b0}}, {WK{1'b1}}};
        end
        assign sign_tab[k]  = {{(DATA_W-1){1'b0}}, 1'b1} << (WK - 1);
        assign width_tab[k] = IDX_W'(WK);
    end

    // select the entry for the presented code, or zeros if unsupported
    always_comb begin
        type_ok = (type_code < TYPE_W'(NUM_WIDTHS));
        if (type_ok) begin
            mask       = mask_tab[type_code[SEL_W-1:0]];
            sign_bit   = sign_tab[type_code[SEL_W-1:0]];
            width_bits = width_tab[type_code[SEL_W-1:0]];
        end else begin
            mask       = '0;
            sign_bit   = '0;
            width_bits = '0;
        end
    end

endmodule

// File: rtl/abu_addsub.sv
// Shared adder: computes a+b or a-b on operands that are already masked, masks
// the sum, and derives the zero, negative, signed-overflow and carry/borrow
// flags at the selected width. The caller supplies the constant 1 as b for
// increment operations.
module abu_addsub #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_m,
    input  logic [DATA_W-1:0] b_m,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] sign_bit,
    input  logic              do_sub,
    output logic [DATA_W-1:0] res_m,
    output logic              zero,
    output logic              neg,
    output logic              ovf,
    output logic              cy
);
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] same_or_diff;
    logic [DATA_W-1:0] flip;

    // single carry chain shared by add, subtract and increment
    always_comb begin
        raw   = do_sub ? (a_m - b_m) : (a_m + b_m);
        res_m = raw & mask;
    end

    // flags derived from the masked result at the selected width
    always_comb begin
        same_or_diff = do_sub ? (a_m ^ b_m) : ~(a_m ^ b_m);
        flip         = a_m ^ raw;
        ovf          = |(same_or_diff & flip & sign_bit);
        zero         = (res_m == '0);
        neg          = |(res_m & sign_bit);
        cy           = do_sub ? (res_m > a_m) : (res_m < a_m);
    end

endmodule

// File: rtl/abu_cond.sv
// Condition selector: picks the raw branch condition for the family and the
// condition index, and reports whether that index is defined for the family.
// Operands are assumed to be masked to the selected width already.
module abu_cond #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = $clog2(DATA_W) + 1
) (
    input  abu_pkg::fam_e                    fam,
    input  logic [abu_pkg::COND_W-1:0]       cidx,
    input  logic [DATA_W-1:0]                a_m,
    input  logic [DATA_W-1:0]                b_m,
    input  logic [DATA_W-1:0]                res_m,
    input  logic [DATA_W-1:0]                sign_bit,
    input  logic [IDX_W-1:0]                 width_bits,
    input  logic                             zero,
    input  logic                             neg,
    input  logic                             ovf,
    input  logic                             cy,
    output logic                             hit,
    output logic                             cond_ok
);
    import abu_pkg::*;

    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W-1:0] a_bias, b_bias, r_bias, a_and_b;
    logic              idx_in_range, bit_val;

    // shared terms: sign-flipped operands for signed compares, bit test
    always_comb begin
        a_bias       = a_m ^ sign_bit;
        b_bias       = b_m ^ sign_bit;
        r_bias       = res_m ^ sign_bit;
        a_and_b      = a_m & b_m;
        idx_in_range = b_m < {{(DATA_W-IDX_W){1'b0}}, width_bits};
        bit_val      = idx_in_range & a_m[b_m[SH_W-1:0]];
    end

    // condition select per family
    always_comb begin
        hit     = 1'b0;
        cond_ok = 1'b1;
        unique case (fam)
            FAM_SUB, FAM_ADD: begin
                case (cidx)
                    CA_ZERO: hit = zero;
                    CA_NEG:  hit = neg;
                    CA_POS:  hit = !neg && !zero;
                    CA_OVF:  hit = ovf;
                    CA_CY:   hit = cy;
                    default: cond_ok = 1'b0;
                endcase
            end
            FAM_AND, FAM_OR, FAM_XOR: begin
                if (cidx == 3'd0) hit = zero;
                else              cond_ok = 1'b0;
            end
            FAM_CMP: begin
                case (cidx)
                    CC_EQ:   hit = (a_m == b_m);
                    CC_SLT:  hit = (a_bias < b_bias);
                    CC_SGT:  hit = (a_bias > b_bias);
                    CC_ULT:  hit = (a_m < b_m);
                    CC_UGT:  hit = (a_m > b_m);
                    default: cond_ok = 1'b0;
                endcase
            end
            FAM_TST: begin
                case (cidx)
                    CT_BIT:  hit = bit_val;
                    CT_ALL:  hit = (a_and_b == b_m);
                    CT_ANY:  hit = (a_and_b != '0);
                    default: cond_ok = 1'b0;
                endcase
            end
            FAM_INC: begin
                case (cidx)
                    CI_LT:   hit = (r_bias < b_bias);
                    CI_GT:   hit = (r_bias > b_bias);
                    default: cond_ok = 1'b0;
                endcase
            end
            default: cond_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/abu_top.sv
// Integer arithmetic-and-branch unit. It masks the operands to the selected
// width, runs the family's operation, picks the condition, applies the invert
// bit and registers the result, decision and fault flag with one cycle of
// latency. It assumes a synchronous active-low reset and a free-running clock.
module abu_top #(
    parameter int DATA_W     = 64,
    parameter int TYPE_W     = 3,
    parameter int NUM_WIDTHS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [abu_pkg::OP_W-1:0]  in_op,
    input  logic [TYPE_W-1:0]         in_type,
    input  logic [DATA_W-1:0]         in_a,
    input  logic [DATA_W-1:0]         in_b,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         out_result,
    output logic                      out_taken,
    output logic                      out_fault
);
    import abu_pkg::*;

    localparam int IDX_W    = $clog2(DATA_W) + 1;
    localparam int NARROW_W = DATA_W >> (NUM_WIDTHS - 1);

    fam_e               fam;
    logic [COND_W-1:0]  cidx;
    logic               inv;
    logic [DATA_W-1:0]  mask, sign_bit, a_m, b_m, b_arith, sum_m, logic_m;
    logic [IDX_W-1:0]   width_bits;
    logic               type_ok, zero, neg, ovf, cy, hit, cond_ok;
    logic               fault_d, taken_d;
    logic [DATA_W-1:0]  result_d;

    // split the opcode into its fields and mask the operands
    always_comb begin
        fam     = fam_e'(in_op[OP_W-1 -: FAM_W]);
        cidx    = in_op[COND_W:1];
        inv     = in_op[0];
        a_m     = in_a & mask;
        b_m     = in_b & mask;
        b_arith = (fam == FAM_INC) ? {{(DATA_W-1){1'b0}}, 1'b1} : b_m;
    end

    abu_width_decode #(
        .DATA_W(DATA_W), .TYPE_W(TYPE_W), .NUM_WIDTHS(NUM_WIDTHS), .IDX_W(IDX_W)
    ) u_width (
        .type_code(in_type), .mask(mask), .sign_bit(sign_bit),
        .width_bits(width_bits), .type_ok(type_ok)
    );

    abu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_m(a_m), .b_m(b_arith), .mask(mask), .sign_bit(sign_bit),
        .do_sub(fam == FAM_SUB), .res_m(sum_m), .zero(zero), .neg(neg),
        .ovf(ovf), .cy(cy)
    );

    // bitwise families share one mux; the adder's zero flag is reused below
    always_comb begin
        case (fam)
            FAM_AND: logic_m = a_m & b_m;
            FAM_OR:  logic_m = a_m | b_m;
            FAM_XOR: logic_m = a_m ^ b_m;
            default: logic_m = '0;
        endcase
    end

    logic zero_sel;
    // zero flag of whichever result the family produces
    always_comb zero_sel = (fam == FAM_AND || fam == FAM_OR || fam == FAM_XOR)
                           ? (logic_m == '0) : zero;

    logic [DATA_W-1:0] res_for_cond;
    // the condition selector sees the family's own result
    always_comb res_for_cond = (fam == FAM_INC) ? sum_m : logic_m;

    abu_cond #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cond (
        .fam(fam), .cidx(cidx), .a_m(a_m), .b_m(b_m), .res_m(res_for_cond),
        .sign_bit(sign_bit), .width_bits(width_bits), .zero(zero_sel),
        .neg(neg), .ovf(ovf), .cy(cy), .hit(hit), .cond_ok(cond_ok)
    );

    // final decision, fault and result before the output register
    always_comb begin
        fault_d = !type_ok || !cond_ok;
        taken_d = !fault_d && (hit ^ inv);
        if (fault_d) begin
            result_d = '0;
        end else begin
            case (fam)
                FAM_SUB, FAM_ADD, FAM_INC: result_d = sum_m;
                FAM_AND, FAM_OR, FAM_XOR:  result_d = logic_m;
                default:                   result_d = '0;
            endcase
        end
    end

    // output register: load on a valid operation, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_taken  <= 1'b0;
            out_fault  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= result_d;
                out_taken  <= taken_d;
                out_fault  <= fault_d;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                          // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                        // R12
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result) && $stable(out_taken) && $stable(out_fault)); // R12
    AST_FAULT_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> !out_taken && (out_result == '0));                  // R11
    AST_BAD_TYPE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_type >= TYPE_W'(NUM_WIDTHS)) |=> out_fault);      // R11
    AST_NARROW_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_type == '0) |=> (out_result >> NARROW_W) == '0);  // R1

endmodule

// File: tb/tb_abu_top.sv
// Scoreboard bench: the driver pushes model-predicted items into a queue, the
// monitor pops one per valid output and compares, and checks hold on idle cycles.
module tb_abu_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [6:0]  in_op;
    logic [2:0]  in_type;
    logic [63:0] in_a, in_b;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_taken, out_fault;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [63:0] res;
        logic        tk;
        logic        flt;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [63:0] last_res = '0;
    logic        last_tk = 1'b0, last_flt = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    abu_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_type(in_type), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_result(out_result), .out_taken(out_taken), .out_fault(out_fault)
    );

    function automatic logic [6:0] mkop(int f, int c, bit i);
        return {f[2:0], c[2:0], i};
    endfunction

    function automatic longint sx(logic [63:0] v, int w);
        return longint'(v << (64 - w)) >>> (64 - w);
    endfunction

    // independent reference model built on sign extension and widened sums
    function automatic exp_t model(logic [6:0] op, logic [2:0] ty,
                                   logic [63:0] a, logic [63:0] b, string tag);
        exp_t e;
        int w, f, c;
        logic [63:0] m, am, bm, r;
        longint sa, sb, sr;
        logic signed [65:0] ea, eb, ex, er;
        logic [64:0] wide;
        bit hit, ok;
        e.tag = tag; e.res = '0; e.tk = 1'b0; e.flt = 1'b0;
        f = int'(op[6:4]); c = int'(op[3:1]);
        if (ty > 3) begin e.flt = 1'b1; return e; end
        w  = 8 << ty;
        m  = (w == 64) ? '1 : ((64'd1 << w) - 1);
        am = a & m; bm = b & m;
        sa = sx(am, w); sb = sx(bm, w);
        hit = 0; ok = 1; r = '0;
        case (f)
            0, 1: begin
                r  = ((f == 0) ? am - bm : am + bm) & m;
                sr = sx(r, w);
                ea = sa; eb = sb; er = sr;
                ex = (f == 0) ? ea - eb : ea + eb;
                wide = {1'b0, am} + {1'b0, bm};
                case (c)
                    0: hit = (r == 0);
                    1: hit = (sr < 0);
                    2: hit = (sr > 0);
                    3: hit = (ex != er);
                    4: hit = (f == 0) ? (am < bm) : (wide > {1'b0, m});
                    default: ok = 0;
                endcase
            end
            2, 3, 4: begin
                r = (f == 2) ? (am & bm) : (f == 3) ? (am | bm) : (am ^ bm);
                if (c == 0) hit = (r == 0); else ok = 0;
            end
            5: case (c)
                0: hit = (am == bm);
                1: hit = (sa < sb);
                2: hit = (sa > sb);
                3: hit = (am < bm);
                4: hit = (am > bm);
                default: ok = 0;
            endcase
            6: case (c)
                0: hit = (bm < 64'(w)) ? am[bm[5:0]] : 1'b0;
                1: hit = ((am & bm) == bm);
                2: hit = ((am & bm) != 0);
                default: ok = 0;
            endcase
            default: begin
                r  = (am + 64'd1) & m;
                sr = sx(r, w);
                case (c)
                    0: hit = (sr < sb);
                    1: hit = (sr > sb);
                    default: ok = 0;
                endcase
            end
        endcase
        if (!ok) begin e.flt = 1'b1; return e; end
        e.res = r;
        e.tk  = hit ^ op[0];
        return e;
    endfunction

    // driver: present one operation for one cycle and queue its prediction
    task automatic drive(logic [6:0] op, logic [2:0] ty, logic [63:0] a,
                         logic [63:0] b, string tag);
        in_valid = 1'b1; in_op = op; in_type = ty; in_a = a; in_b = b;
        sb_q.push_back(model(op, ty, a, b, tag));
        @(negedge clk);
    endtask

    // idle cycle with junk on the data inputs
    task automatic idle();
        in_valid = 1'b0; in_op = 7'($urandom); in_type = 3'($urandom);
        in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom};
        @(negedge clk);
    endtask

    // monitor: compare each valid output; check the hold on idle cycles
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (out_valid) begin
                total++;
                if (sb_q.size() == 0) begin
                    bad++;
                    $display("FAIL R2: unexpected out_valid, actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (out_result !== e.res || out_taken !== e.tk || out_fault !== e.flt) begin
                        bad++;
                        $display("FAIL %s: actual res=%h tk=%b flt=%b expected res=%h tk=%b flt=%b",
                                 e.tag, out_result, out_taken, out_fault, e.res, e.tk, e.flt);
                    end
                end
                last_res = out_result; last_tk = out_taken; last_flt = out_fault;
            end else begin
                total++;
                if (out_result !== last_res || out_taken !== last_tk || out_fault !== last_flt) begin
                    bad++;
                    $display("FAIL R12: idle changed outputs, actual res=%h tk=%b flt=%b expected res=%h tk=%b flt=%b",
                             out_result, out_taken, out_fault, last_res, last_tk, last_flt);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_type = '0;
        in_a = '1; in_b = '1;
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_result !== '0 || out_taken !== 1'b0 || out_fault !== 1'b0) begin
            bad++;
            $display("FAIL R2: reset state actual v=%b r=%h t=%b f=%b expected all zero",
                     out_valid, out_result, out_taken, out_fault);
        end
        rst_n = 1'b1;

        // subtract family, masking with junk upper bits
        drive(mkop(0,1,0), 3'd0, 64'hABCD_0005, 64'h1234_0007, "R3_neg_R1");
        drive(mkop(0,0,0), 3'd1, 64'hFFFF_1234, 64'h0000_1234, "R3_zero");
        drive(mkop(0,0,1), 3'd1, 64'hFFFF_1234, 64'h0000_1234, "R10_inv");
        drive(mkop(0,2,0), 3'd2, 64'd10, 64'd3, "R3_pos");
        drive(mkop(0,2,0), 3'd2, 64'd3, 64'd3, "R3_pos_zero");
        drive(mkop(0,3,0), 3'd0, 64'hFF80, 64'h01, "R5_sub_ovf");
        drive(mkop(0,4,0), 3'd0, 64'h7703, 64'h05, "R3_borrow");
        drive(mkop(0,4,0), 3'd3, 64'h5, 64'h0, "R3_no_borrow");
        idle(); idle();
        // add family
        drive(mkop(1,4,0), 3'd0, 64'hFF, 64'h01, "R4_carry");
        drive(mkop(1,0,0), 3'd0, 64'h3FF, 64'h01, "R4_zero_R1");
        drive(mkop(1,3,0), 3'd0, 64'h7F, 64'h01, "R5_add_ovf");
        drive(mkop(1,3,0), 3'd0, 64'h80, 64'h7F, "R5_add_no_ovf");
        drive(mkop(1,4,0), 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R4_carry64");
        drive(mkop(1,1,0), 3'd2, 64'h7FFF_FFFF, 64'd1, "R4_neg32");
        // bitwise families
        drive(mkop(2,0,0), 3'd0, 64'hF00, 64'h0F0, "R6_and_zero");
        drive(mkop(3,0,0), 3'd1, 64'h0001_0000, 64'h0, "R6_or_masked");
        drive(mkop(4,0,0), 3'd2, 64'h1_1234_5678, 64'h1234_5678, "R6_xor");
        drive(mkop(2,1,0), 3'd0, 64'h1, 64'h1, "R11_bad_cond_logic");
        // compare family
        drive(mkop(5,1,0), 3'd0, 64'h80, 64'h01, "R7_slt");
        drive(mkop(5,3,0), 3'd0, 64'h80, 64'h01, "R7_ult");
        drive(mkop(5,0,0), 3'd0, 64'h1_55, 64'h2_55, "R7_eq_masked");
        drive(mkop(5,2,0), 3'd3, 64'h1, 64'h8000_0000_0000_0000, "R7_sgt64");
        drive(mkop(5,4,1), 3'd1, 64'hFFFF, 64'h1, "R7_ugt_inv_R10");
        drive(mkop(5,5,0), 3'd0, 64'h1, 64'h1, "R11_bad_cond_cmp");
        // bit tests
        drive(mkop(6,0,0), 3'd0, 64'h80, 64'd7, "R8_bit7");
        drive(mkop(6,0,0), 3'd1, 64'h1_0000, 64'd16, "R8_idx_eq_width");
        drive(mkop(6,0,0), 3'd0, 64'h80, 64'h107, "R8_idx_masked");
        drive(mkop(6,0,0), 3'd3, 64'h8000_0000_0000_0000, 64'd63, "R8_bit63");
        drive(mkop(6,1,0), 3'd2, 64'hF0F0, 64'h3030, "R8_all");
        drive(mkop(6,2,0), 3'd2, 64'hF0F0, 64'h0F0F, "R8_any");
        // increment-compare
        drive(mkop(7,0,0), 3'd0, 64'h7F, 64'h00, "R9_lt_wrap");
        drive(mkop(7,1,0), 3'd1, 64'h0010, 64'h0010, "R9_gt");
        drive(mkop(7,2,0), 3'd1, 64'h0010, 64'h0010, "R11_bad_cond_inc");
        // unsupported widths
        drive(mkop(1,0,0), 3'd4, 64'h0, 64'h0, "R11_type4");
        drive(mkop(5,0,1), 3'd7, 64'h5, 64'h5, "R11_type7");
        idle(); idle(); idle();

        // random mix over every legal family, condition and width
        for (int n = 0; n < 400; n++) begin
            int f, c, lim;
            logic [63:0] b;
            f = int'($urandom % 8);
            case (f)
                0, 1, 5: lim = 5;
                6:       lim = 3;
                7:       lim = 2;
                default: lim = 1;
            endcase
            c = int'($urandom % lim);
            b = {$urandom, $urandom};
            if (f == 6 && c == 0) b = 64'($urandom % 80);
            drive(mkop(f, c, 1'($urandom)), 3'($urandom % 4), {$urandom, $urandom}, b, "R10_random_mix");
            if (n % 7 == 0) idle();
        end
        idle(); idle();

        total++;
        if (sb_q.size() != 0) begin
            bad++;
            $display("FAIL R2: items left actual=%0d expected=0", sb_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule